// File: doc/BRIEF.md
# Three-Class Interrupt Controller

This block gathers up to 32 level-sensitive interrupt requests from peripherals and sorts each into one of three priority classes. The highest class is the fast class. Every enabled request marked for it is merged onto a single fast line. The middle class has sixteen ranked slots. Each slot names one source and carries a handler address. All remaining enabled requests form the lowest class, and they share one fallback handler address. Any request in the middle or lowest class raises the normal interrupt line.

Software programs the block through a small word-addressed register bus. At run time it can move any source between classes, or retarget any slot. The processor reads the vector word to learn where to jump. That word holds the address of the highest-ranked slot whose source is pending. When no slot is pending, it holds the fallback address. Status words show raw requests, fast-class requests and normal-class requests, so a shared handler can find its sources.

Top module: `intc_tri_class`

## Requirements
- R1: A source takes part only while its bit is set in the enable mask. Writing word 1 ORs the written ones into the mask. Writing word 2 clears the mask bits written as one. Reading word 1 returns the mask. Reading word 2 returns 0.
- R2: `fiq_o` is high one clock after any source is requesting, enabled and selected for the fast class. It is low one clock after no such source exists. Word 3 holds the fast-class select mask (bit n = source n).
- R3: Word 0 reads the raw request inputs. Word 4 reads requesting, enabled, fast-selected sources. Word 5 reads requesting, enabled, non-fast sources.
- R4: `irq_o` is high one clock after any source is requesting, enabled and not fast-selected. It is low otherwise.
- R5: Slot n has a control word at 16+n and an address word at 32+n. In the control word, bits 4:0 are the source number and bit 5 is the slot enable. A slot whose enable is clear never matches.
- R6: Word 6, the vector word, holds the address of the lowest-numbered enabled slot whose source is pending in the normal class. Slot 0 wins over all others. The vector word updates one clock after its inputs change.
- R7: When no slot matches, word 6 holds the fallback address, which is written and read at word 7.
- R8: A fast-selected source never matches a slot. Clearing its select bit at run time moves it into the normal class, so it matches its slot and raises `irq_o`.
- R9: Reset is synchronous and active high. It clears the enable mask, the select mask, the fallback address and all slot words, so both interrupt lines are low after reset.
- R10: Read data appears on `bus_rdata` the clock after a read request and is 0 in cycles with no read. Undefined words read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NSRC | Level-sensitive interrupt requests |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| fiq_o | output | 1 | Combined fast interrupt line |
| irq_o | output | 1 | Combined normal interrupt line |

## Verification
The bench targets slot ranking when two pending sources sit in different slots. A design that scanned slots in the wrong direction would return the lower-ranked address. It also covers a slot pointing at a fast-selected source, which a wrong design would vector to, and a disabled slot naming a pending source, which must leave the fallback address in place. A run-time change of class and writes to unmapped or write-one-to-clear words are both checked, since a decoder slip there silently alters the masks. A long random phase then compares every line and every read against a behavioural model on each clock, which exposes any extra or missing register stage.

// File: rtl/intc_tc_pkg.sv
package intc_tc_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] A_RAW      = 6'd0;
  localparam logic [ADDR_W-1:0] A_EN_SET   = 6'd1;
  localparam logic [ADDR_W-1:0] A_EN_CLR   = 6'd2;
  localparam logic [ADDR_W-1:0] A_FSEL     = 6'd3;
  localparam logic [ADDR_W-1:0] A_FIQ_ST   = 6'd4;
  localparam logic [ADDR_W-1:0] A_IRQ_ST   = 6'd5;
  localparam logic [ADDR_W-1:0] A_VEC      = 6'd6;
  localparam logic [ADDR_W-1:0] A_DEF      = 6'd7;
  localparam logic [ADDR_W-1:0] A_SLOT_CTL = 6'd16;
  localparam logic [ADDR_W-1:0] A_SLOT_ADR = 6'd32;
  localparam int MAX_SLOTS = 16;
endpackage

// File: rtl/intc_src_class.sv
module intc_src_class #(
  parameter int NSRC = 32
) (
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] fsel,
  output logic [NSRC-1:0] fiq_act,
  output logic [NSRC-1:0] irq_act
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic live;
    assign live       = req[i] & en[i];
    assign fiq_act[i] = live & fsel[i];
    assign irq_act[i] = live & ~fsel[i];
  end
endmodule

// File: rtl/intc_slot_pick.sv
module intc_slot_pick #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int DW    = 32,
  parameter int SRC_W = 5
) (
  input  logic [NSRC-1:0]             irq_act,
  input  logic [NSLOT-1:0][SRC_W-1:0] slot_src,
  input  logic [NSLOT-1:0]            slot_on,
  input  logic [NSLOT-1:0][DW-1:0]    slot_adr,
  input  logic [DW-1:0]               def_adr,
  output logic [DW-1:0]               pick_adr
);
  logic [NSLOT-1:0] hit;

  for (genvar s = 0; s < NSLOT; s++) begin : g_hit
    logic src_ok;
    assign src_ok = (int'(slot_src[s]) < NSRC) ? irq_act[slot_src[s]] : 1'b0;
    assign hit[s] = slot_on[s] & src_ok;
  end

  // lowest index has the highest rank, so it is applied last
  always_comb begin
    pick_adr = def_adr;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (hit[s]) pick_adr = slot_adr[s];
    end
  end
endmodule

// File: rtl/intc_tri_class.sv
module intc_tri_class
  import intc_tc_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int DW    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   req_i,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              fiq_o,
  output logic              irq_o
);
  localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int CTL_W = SRC_W + 1;

  logic [NSRC-1:0]             en_q;
  logic [NSRC-1:0]             fsel_q;
  logic [DW-1:0]               def_q;
  logic [NSLOT-1:0][SRC_W-1:0] slot_src_q;
  logic [NSLOT-1:0]            slot_on_q;
  logic [NSLOT-1:0][DW-1:0]    slot_adr_q;
  logic [DW-1:0]               vec_q;
  logic [DW-1:0]               rdata_q;
  logic                        fiq_q;
  logic                        irq_q;

  logic [NSRC-1:0] fiq_act;
  logic [NSRC-1:0] irq_act;
  logic [DW-1:0]   pick_adr;
  logic [DW-1:0]   rd_mux;
  logic            wr;
  logic            rd;

  assign wr = bus_sel & bus_we;
  assign rd = bus_sel & ~bus_we;

  intc_src_class #(.NSRC(NSRC)) u_class (
    .req     (req_i),
    .en      (en_q),
    .fsel    (fsel_q),
    .fiq_act (fiq_act),
    .irq_act (irq_act)
  );

  intc_slot_pick #(
    .NSRC(NSRC), .NSLOT(NSLOT), .DW(DW), .SRC_W(SRC_W)
  ) u_pick (
    .irq_act  (irq_act),
    .slot_src (slot_src_q),
    .slot_on  (slot_on_q),
    .slot_adr (slot_adr_q),
    .def_adr  (def_q),
    .pick_adr (pick_adr)
  );

  // global configuration words
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      fsel_q <= '0;
      def_q  <= '0;
    end else if (wr) begin
      case (bus_addr)
        A_EN_SET: en_q   <= en_q | bus_wdata[NSRC-1:0];
        A_EN_CLR: en_q   <= en_q & ~bus_wdata[NSRC-1:0];
        A_FSEL:   fsel_q <= bus_wdata[NSRC-1:0];
        A_DEF:    def_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  // per-slot control and address words
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_src_q <= '0;
      slot_on_q  <= '0;
      slot_adr_q <= '0;
    end else if (wr) begin
      for (int s = 0; s < NSLOT; s++) begin
        if (bus_addr == A_SLOT_CTL + ADDR_W'(s)) begin
          slot_src_q[s] <= bus_wdata[SRC_W-1:0];
          slot_on_q[s]  <= bus_wdata[SRC_W];
        end
        if (bus_addr == A_SLOT_ADR + ADDR_W'(s)) begin
          slot_adr_q[s] <= bus_wdata;
        end
      end
    end
  end

  // read selection
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_RAW:    rd_mux = DW'(req_i);
      A_EN_SET: rd_mux = DW'(en_q);
      A_FSEL:   rd_mux = DW'(fsel_q);
      A_FIQ_ST: rd_mux = DW'(fiq_act);
      A_IRQ_ST: rd_mux = DW'(irq_act);
      A_VEC:    rd_mux = vec_q;
      A_DEF:    rd_mux = def_q;
      default: ;
    endcase
    for (int s = 0; s < NSLOT; s++) begin
      if (bus_addr == A_SLOT_CTL + ADDR_W'(s))
        rd_mux = DW'(CTL_W'({slot_on_q[s], slot_src_q[s]}));
      if (bus_addr == A_SLOT_ADR + ADDR_W'(s))
        rd_mux = slot_adr_q[s];
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      fiq_q   <= 1'b0;
      irq_q   <= 1'b0;
      vec_q   <= '0;
      rdata_q <= '0;
    end else begin
      fiq_q   <= |fiq_act;
      irq_q   <= |irq_act;
      vec_q   <= pick_adr;
      rdata_q <= rd ? rd_mux : '0;
    end
  end

  assign fiq_o     = fiq_q;
  assign irq_o     = irq_q;
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/intc_tri_class_chk.sv
module intc_tri_class_chk #(
  parameter int NSRC = 32,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] req_i,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] fsel_q,
  input logic            bus_sel,
  input logic            bus_we,
  input logic [DW-1:0]   bus_rdata,
  input logic            fiq_o,
  input logic            irq_o
);
  // R2
  a_r2_fiq_raise: assert property (@(posedge clk) disable iff (rst)
    (|(req_i & en_q & fsel_q)) |=> fiq_o);
  // R2
  a_r2_fiq_drop: assert property (@(posedge clk) disable iff (rst)
    !(|(req_i & en_q & fsel_q)) |=> !fiq_o);
  // R4
  a_r4_irq_raise: assert property (@(posedge clk) disable iff (rst)
    (|(req_i & en_q & ~fsel_q)) |=> irq_o);
  // R1
  a_r1_masked_silent: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> (!fiq_o && !irq_o));
  // R9
  a_r9_reset_low: assert property (@(posedge clk)
    rst |=> (!fiq_o && !irq_o));
  // R10
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_we) |=> (bus_rdata == '0));
endmodule

bind intc_tri_class intc_tri_class_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_i     (req_i),
  .en_q      (en_q),
  .fsel_q    (fsel_q),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .fiq_o     (fiq_o),
  .irq_o     (irq_o)
);

// File: tb/intc_tri_class_test.sv
`timescale 1ns/1ps
module intc_tri_class_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] req = '0;
  logic        sel = 1'b0;
  logic        we  = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fiq;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  bit chk_on = 0;

  always #10 clk = ~clk;

  intc_tri_class uut (
    .clk(clk), .rst(rst), .req_i(req), .bus_sel(sel), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .fiq_o(fiq), .irq_o(irq)
  );

  // behavioural model state
  logic [31:0] m_en, m_fs, m_def;
  logic [4:0]  m_src [16];
  bit          m_on  [16];
  logic [31:0] m_adr [16];
  logic [31:0] exp_vec, exp_rdata;
  bit          exp_fiq, exp_irq;

  function automatic logic [31:0] mread(input int a);
    if (a == 0) return req;
    if (a == 1) return m_en;
    if (a == 3) return m_fs;
    if (a == 4) return req & m_en & m_fs;
    if (a == 5) return req & m_en & ~m_fs;
    if (a == 6) return exp_vec;
    if (a == 7) return m_def;
    if (a >= 16 && a < 32) return {26'd0, m_on[a-16], m_src[a-16]};
    if (a >= 32 && a < 48) return m_adr[a-32];
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_fs = 0; m_def = 0;
      for (int s = 0; s < 16; s++) begin m_src[s] = 0; m_on[s] = 0; m_adr[s] = 0; end
      exp_vec = 0; exp_rdata = 0; exp_fiq = 0; exp_irq = 0;
    end else begin
      logic [31:0] act_i, nv;
      int ia;
      bit found;
      ia = int'(addr);
      exp_rdata = (sel && !we) ? mread(ia) : 32'd0;
      act_i = req & m_en & ~m_fs;
      nv = m_def;
      found = 0;
      for (int s = 0; s < 16; s++)
        if (!found && m_on[s] && act_i[m_src[s]]) begin nv = m_adr[s]; found = 1; end
      exp_vec = nv;
      exp_fiq = |(req & m_en & m_fs);
      exp_irq = |act_i;
      if (sel && we) begin
        if (ia == 1) m_en = m_en | wdata;
        else if (ia == 2) m_en = m_en & ~wdata;
        else if (ia == 3) m_fs = wdata;
        else if (ia == 7) m_def = wdata;
        else if (ia >= 16 && ia < 32) begin m_src[ia-16] = wdata[4:0]; m_on[ia-16] = wdata[5]; end
        else if (ia >= 32 && ia < 48) m_adr[ia-32] = wdata;
      end
      chk_on = 1;
    end
  end

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (chk_on && !rst && !done) begin
      check(32'(fiq), 32'(exp_fiq), "R2 fast line vs model");
      check(32'(irq), 32'(exp_irq), "R4 normal line vs model");
      check(rdata, exp_rdata, "R10 read data vs model");
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); sel = 1; we = 1; addr = 6'(a); wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic rd_expect(input int a, input logic [31:0] e, input string tag);
    @(negedge clk); sel = 1; we = 0; addr = 6'(a);
    @(negedge clk); sel = 0;
    check(rdata, e, tag);
  endtask

  task automatic set_req(input logic [31:0] v);
    @(negedge clk); req = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9: reset state
    check(32'(fiq), 0, "R9 fast line after reset");
    check(32'(irq), 0, "R9 normal line after reset");
    rd_expect(1, 0, "R9 enable mask after reset");
    rd_expect(16, 0, "R9 slot 0 control after reset");
    rd_expect(6, 0, "R9 vector after reset");

    // R1: set/clear of the enable mask
    wr(7, 32'hDEF0_0000);
    wr(1, 32'h0000_00FF);
    wr(2, 32'h0000_0080);
    rd_expect(1, 32'h7F, "R1 enable mask after set then clear");
    rd_expect(2, 0, "R1 clear word reads zero");

    // R2/R3: fast class
    wr(3, 32'h4);
    set_req(32'h4);
    check(32'(fiq), 1, "R2 fast line raised");
    check(32'(irq), 0, "R4 normal line stays low");
    rd_expect(4, 32'h4, "R3 fast status");
    rd_expect(0, 32'h4, "R3 raw status");

    // R1: disabled source ignored
    set_req(32'h200);
    check(32'(irq), 0, "R1 masked source gives no normal line");
    rd_expect(5, 0, "R1 masked source absent from normal status");

    // R5/R6: slots
    wr(16, 32'h23); wr(32, 32'h100);
    wr(17, 32'h25); wr(33, 32'h200);
    wr(18, 32'h03); wr(34, 32'h300);
    set_req(32'h20);
    rd_expect(6, 32'h200, "R6 single pending slot");
    set_req(32'h28);
    rd_expect(6, 32'h100, "R6 slot 0 outranks slot 1");
    rd_expect(17, 32'h25, "R5 slot control readback");

    // R7: no slot match
    set_req(32'h40);
    check(32'(irq), 1, "R4 normal line for unslotted source");
    rd_expect(6, 32'hDEF0_0000, "R7 fallback address");
    rd_expect(5, 32'h40, "R3 normal status");

    // R8: fast source never matches a slot, then reclassify
    wr(19, 32'h22); wr(35, 32'h400);
    set_req(32'h4);
    rd_expect(6, 32'hDEF0_0000, "R8 fast source does not vector");
    wr(3, 32'h0);
    repeat (2) @(negedge clk);
    check(32'(fiq), 0, "R8 fast line drops after reclass");
    check(32'(irq), 1, "R8 normal line after reclass");
    rd_expect(6, 32'h400, "R8 reclassified source vectors");

    // R5: disabled slot never matches
    wr(20, 32'h06); wr(36, 32'h500);
    set_req(32'h40);
    rd_expect(6, 32'hDEF0_0000, "R5 disabled slot ignored");
    wr(31, 32'h26); wr(47, 32'hF00);
    repeat (2) @(negedge clk);
    rd_expect(6, 32'hF00, "R5 slot 15 matches");

    // R10: undefined word
    wr(10, 32'hFFFF_FFFF);
    rd_expect(10, 0, "R10 undefined word reads zero");
    rd_expect(1, 32'h7F, "R10 undefined write leaves mask");

    // random phase, checked by the model every clock
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      req = (k % 3 == 0) ? $urandom : ($urandom & $urandom & $urandom);
      sel = ($urandom % 3) == 0;
      we  = $urandom % 2;
      addr = 6'($urandom % 50);
      wdata = $urandom;
      if (we && addr == 6'd2) wdata = wdata & $urandom;
    end
    @(negedge clk); sel = 0; we = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule